// File: doc/BRIEF.md
# Double-Precision Round-to-Integral Unit

This block takes one binary64 floating-point operand and returns the nearest integral value in the same format. A 2-bit mode input picks the direction: toward zero, toward negative infinity, or toward positive infinity. The result is registered. A beat presented with `in_valid` high produces `out_valid` high on the next clock edge, with the rounded value on `out_result`.

Rounding toward zero needs only bit-field work. The unbiased exponent tells how many fraction bits lie below the binary point, and a mask clears them. The two directed modes start from that chopped value. When the operand has the matching sign and the mask threw away a nonzero bit, the magnitude is raised by one unit. This is done by adding a single bit at the units position of the exponent-and-fraction field. A carry out of the fraction therefore lands in the exponent field. No floating-point adder is involved.

The exponent and fraction widths are parameters (11 and 52 by default). The output register can be removed with a parameter to get a purely combinational variant.

Top module: `frnd_unit`

## Requirements
- R1: Mode 00 (toward zero), with an unbiased exponent e = field[62:52] − 1023 in 0..51, returns the operand with its lowest 52 − e fraction bits cleared. Sign, exponent field and the upper fraction bits are kept.
- R2: Mode 00 with a negative unbiased exponent (magnitude below 1.0, including subnormals) returns a zero that carries the operand's sign bit (bit 63) and has all other bits clear.
- R3: An operand whose unbiased exponent is above 51 is returned bit-for-bit unchanged in every mode. This includes infinities and NaNs (exponent field all ones).
- R4: Mode 01 (toward negative infinity) on a negative operand that has a nonzero bit below the binary point returns the chopped value with its magnitude raised by exactly one.
- R5: Mode 10 (toward positive infinity) on a positive operand that has a nonzero bit below the binary point returns the chopped value plus one.
- R6: Mode 01 on a positive operand, mode 10 on a negative operand, and either mode on an operand that is already integral all return the mode-00 result.
- R7: When a directed mode raises an operand whose magnitude is below 1.0 (subnormals included), the result is exactly ±1.0 with the operand's sign: exponent field 1023, fraction zero.
- R8: When raising the magnitude carries out of the fraction field, the exponent field rises by one and the fraction becomes zero (for example 1.5 → 2.0 upward, −7.25 → −8.0 downward).
- R9: The sign bit of the result always equals the operand's sign bit, so −0.0 stays −0.0 in all modes. Mode 11 behaves exactly like mode 00.
- R10: `out_valid` equals `in_valid` delayed by one clock. `out_result` is loaded only on cycles where `in_valid` is high and holds its value otherwise.
- R11: A synchronous active-high `rst` clears `out_valid` and `out_result` to zero on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand beat present |
| in_mode | input | 2 | 00 toward zero, 01 toward −inf, 10 toward +inf, 11 as 00 |
| in_operand | input | 64 | binary64 operand |
| out_valid | output | 1 | Result beat present, one cycle after `in_valid` |
| out_result | output | 64 | Integral-valued binary64 result |

## Verification
The stimulus targets the edges of the exponent range. Exponent 51, with a single fraction bit below the point, exposes a mask that is off by one position: such a design clears a bit it should keep or keeps one it should clear. Exponent 52 checks that a design does not wrongly mask operands that are already integral. Operands of all-ones fraction check that a carry out of the fraction increments the exponent rather than wrapping to a smaller value. Subnormal and signed-zero operands catch a design that tests only the exponent, or one that ignores the sign bit: it would round a positive subnormal upward to zero, or turn −0.0 into +0.0. NaN and infinity operands in the directed modes catch a step gate that does not look at inexactness, which would corrupt the special encodings.

// File: rtl/frnd_pkg.sv
package frnd_pkg;

    // Rounding direction select, decoded from the 2-bit mode input.
    typedef enum logic [1:0] {
        RND_CHOP = 2'b00,
        RND_DOWN = 2'b01,
        RND_UP   = 2'b10,
        RND_ALT  = 2'b11
    } rnd_mode_e;

    localparam int DEF_EXP_W  = 11;
    localparam int DEF_FRAC_W = 52;

endpackage

// File: rtl/frnd_unpack.sv
module frnd_unpack #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0]  operand,
    output logic                   sign,
    output logic signed [EXP_W+1:0] unb_exp,
    output logic                   below_one,
    output logic                   whole
);
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam logic signed [EXP_W+1:0] BIAS_S = (EXP_W+2)'(BIAS);
    localparam logic signed [EXP_W+1:0] FRAC_S = (EXP_W+2)'(FRAC_W);

    logic [EXP_W-1:0] exp_field;

    always_comb begin
        sign      = operand[WORD_W-1];
        exp_field = operand[WORD_W-2:FRAC_W];
        unb_exp   = $signed({2'b00, exp_field}) - BIAS_S;
        below_one = (unb_exp < 0);
        whole     = (unb_exp >= FRAC_S);
    end

endmodule

// File: rtl/frnd_chop.sv
module frnd_chop #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0]   operand,
    input  logic signed [EXP_W+1:0] unb_exp,
    input  logic                    below_one,
    input  logic                    whole,
    output logic [EXP_W+FRAC_W:0]   chopped,
    output logic                    inexact,
    output logic [EXP_W+FRAC_W-1:0] unit
);
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int MAG_W  = WORD_W - 1;
    localparam int SH_W   = $clog2(FRAC_W);
    localparam logic [FRAC_W-1:0] FRAC_ONES = '1;

    logic [SH_W-1:0]   shamt;
    logic [FRAC_W-1:0] below_mask;
    logic [FRAC_W-1:0] frac;

    always_comb begin
        shamt      = unb_exp[SH_W-1:0];
        below_mask = FRAC_ONES >> shamt;
        frac       = operand[FRAC_W-1:0];
        chopped    = operand;
        inexact    = 1'b0;
        unit       = '0;
        if (whole) begin
            chopped = operand;
        end else if (below_one) begin
            chopped = {operand[WORD_W-1], {MAG_W{1'b0}}};
            inexact = |operand[MAG_W-1:0];
        end else begin
            chopped = {operand[WORD_W-1:FRAC_W], frac & ~below_mask};
            inexact = |(frac & below_mask);
            unit    = MAG_W'(below_mask) + MAG_W'(1);
        end
    end

endmodule

// File: rtl/frnd_step.sv
module frnd_step
    import frnd_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  rnd_mode_e               mode,
    input  logic [EXP_W+FRAC_W:0]   chopped,
    input  logic                    inexact,
    input  logic                    below_one,
    input  logic [EXP_W+FRAC_W-1:0] unit,
    output logic [EXP_W+FRAC_W:0]   result
);
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int MAG_W  = WORD_W - 1;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam logic [MAG_W-1:0] ONE_MAG = MAG_W'(BIAS) << FRAC_W;

    logic sign;
    logic away;

    always_comb begin
        sign = chopped[WORD_W-1];
        away = inexact && (((mode == RND_DOWN) && sign) ||
                           ((mode == RND_UP)   && !sign));
        if (!away) begin
            result = chopped;
        end else if (below_one) begin
            result = {sign, ONE_MAG};
        end else begin
            result = {sign, chopped[MAG_W-1:0] + unit};
        end
    end

endmodule

// File: rtl/frnd_unit.sv
module frnd_unit
    import frnd_pkg::*;
#(
    parameter int EXP_W   = DEF_EXP_W,
    parameter int FRAC_W  = DEF_FRAC_W,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [1:0]            in_mode,
    input  logic [EXP_W+FRAC_W:0] in_operand,
    output logic                  out_valid,
    output logic [EXP_W+FRAC_W:0] out_result
);
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int MAG_W  = WORD_W - 1;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] res;
    } stage_t;

    logic                    op_sign;
    logic signed [EXP_W+1:0] unb_exp;
    logic                    below_one;
    logic                    whole;
    logic [WORD_W-1:0]       chopped;
    logic                    inexact;
    logic [MAG_W-1:0]        unit;
    logic [WORD_W-1:0]       result_c;
    rnd_mode_e               mode_sel;

    assign mode_sel = rnd_mode_e'(in_mode);

    frnd_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
        .operand   (in_operand),
        .sign      (op_sign),
        .unb_exp   (unb_exp),
        .below_one (below_one),
        .whole     (whole)
    );

    frnd_chop #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chop (
        .operand   (in_operand),
        .unb_exp   (unb_exp),
        .below_one (below_one),
        .whole     (whole),
        .chopped   (chopped),
        .inexact   (inexact),
        .unit      (unit)
    );

    frnd_step #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_step (
        .mode      (mode_sel),
        .chopped   (chopped),
        .inexact   (inexact),
        .below_one (below_one),
        .unit      (unit),
        .result    (result_c)
    );

    generate
        if (OUT_REG) begin : g_reg
            stage_t stage_d;
            stage_t stage_q;

            always_comb begin
                stage_d     = stage_q;
                stage_d.vld = in_valid;
                if (in_valid) begin
                    stage_d.res = result_c;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q <= '0;
                end else begin
                    stage_q <= stage_d;
                end
            end

            assign out_valid  = stage_q.vld;
            assign out_result = stage_q.res;
        end else begin : g_comb
            assign out_valid  = in_valid;
            assign out_result = result_c;
        end
    endgenerate

    // The sign is carried through the chop path; sampled here only so the
    // decoded value has a reader in every configuration.
    logic sign_unused;
    assign sign_unused = op_sign;

endmodule

// File: rtl/frnd_unit_chk.sv
module frnd_unit_chk
    import frnd_pkg::*;
#(
    parameter int EXP_W   = 11,
    parameter int FRAC_W  = 52,
    parameter bit OUT_REG = 1'b1
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic [1:0]            in_mode,
    input logic [EXP_W+FRAC_W:0] in_operand,
    input logic                  out_valid,
    input logic [EXP_W+FRAC_W:0] out_result
);
    localparam int WORD_W = 1 + EXP_W + FRAC_W;

    generate
        if (OUT_REG) begin : g_seq
            a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> out_valid);

            a_r10_idle_drops: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> !out_valid);

            a_r10_result_holds: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> $stable(out_result));

            a_r11_reset_clears: assert property (@(posedge clk)
                rst |=> (!out_valid && (out_result == '0)));

            a_r3_special_pass: assert property (@(posedge clk) disable iff (rst)
                (in_valid && (&in_operand[WORD_W-2:FRAC_W]))
                |=> (out_result == $past(in_operand)));

            a_r9_sign_kept: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> (out_result[WORD_W-1] == $past(in_operand[WORD_W-1])));

            a_r1_chop_no_grow: assert property (@(posedge clk) disable iff (rst)
                (in_valid && (in_mode == RND_CHOP))
                |=> (out_result[WORD_W-2:0] <= $past(in_operand[WORD_W-2:0])));
        end else begin : g_comb
            always_comb begin
                if (in_valid) begin
                    a_r9_sign_kept_c: assert (out_result[WORD_W-1] == in_operand[WORD_W-1]);
                end
            end
        end
    endgenerate

endmodule

bind frnd_unit frnd_unit_chk #(
    .EXP_W   (EXP_W),
    .FRAC_W  (FRAC_W),
    .OUT_REG (OUT_REG)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_mode    (in_mode),
    .in_operand (in_operand),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/frnd_unit_bench.sv
`timescale 1ns/1ps
module frnd_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  in_mode;
    logic [63:0] in_operand;
    logic        out_valid;
    logic [63:0] out_result;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    frnd_unit u_frnd_unit (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_mode    (in_mode),
        .in_operand (in_operand),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    // {requirement number, mode, operand, expected}
    localparam int NV = 33;
    localparam logic [137:0] VEC [NV] = '{
        {8'd1, 2'd0, 64'h3FF8000000000000, 64'h3FF0000000000000}, // R1  1.5
        {8'd1, 2'd0, 64'hC01D000000000000, 64'hC01C000000000000}, // R1  -7.25
        {8'd1, 2'd0, 64'h4320000000000001, 64'h4320000000000000}, // R1  e=51
        {8'd2, 2'd0, 64'h3FE0000000000000, 64'h0000000000000000}, // R2  0.5
        {8'd2, 2'd0, 64'hBFD0000000000000, 64'h8000000000000000}, // R2  -0.25
        {8'd2, 2'd0, 64'h8000000000000001, 64'h8000000000000000}, // R2  -subnormal
        {8'd3, 2'd1, 64'h7FF8000000000001, 64'h7FF8000000000001}, // R3  NaN
        {8'd3, 2'd2, 64'h7FF0000000000000, 64'h7FF0000000000000}, // R3  +inf
        {8'd3, 2'd1, 64'hFFF0000000000000, 64'hFFF0000000000000}, // R3  -inf
        {8'd3, 2'd2, 64'h4330000000000001, 64'h4330000000000001}, // R3  e=52
        {8'd3, 2'd1, 64'hC340000000000001, 64'hC340000000000001}, // R3  e=53
        {8'd4, 2'd1, 64'hBFF8000000000000, 64'hC000000000000000}, // R4  -1.5
        {8'd4, 2'd1, 64'hC320000000000001, 64'hC320000000000002}, // R4  e=51
        {8'd5, 2'd2, 64'h4006000000000000, 64'h4008000000000000}, // R5  2.75
        {8'd5, 2'd2, 64'h4320000000000001, 64'h4320000000000002}, // R5  e=51
        {8'd6, 2'd1, 64'h4006000000000000, 64'h4000000000000000}, // R6
        {8'd6, 2'd2, 64'hC01D000000000000, 64'hC01C000000000000}, // R6
        {8'd6, 2'd2, 64'h4008000000000000, 64'h4008000000000000}, // R6  exact 3
        {8'd6, 2'd1, 64'hC008000000000000, 64'hC008000000000000}, // R6  exact -3
        {8'd6, 2'd1, 64'h3FE0000000000000, 64'h0000000000000000}, // R6  0.5 down
        {8'd7, 2'd2, 64'h3FE0000000000000, 64'h3FF0000000000000}, // R7
        {8'd7, 2'd1, 64'hBFD0000000000000, 64'hBFF0000000000000}, // R7
        {8'd7, 2'd2, 64'h0000000000000001, 64'h3FF0000000000000}, // R7  subnormal
        {8'd7, 2'd1, 64'h8000000000000001, 64'hBFF0000000000000}, // R7  subnormal
        {8'd8, 2'd2, 64'h3FF8000000000000, 64'h4000000000000000}, // R8
        {8'd8, 2'd1, 64'hC01D000000000000, 64'hC020000000000000}, // R8
        {8'd8, 2'd2, 64'h432FFFFFFFFFFFFF, 64'h4330000000000000}, // R8
        {8'd8, 2'd1, 64'hBFFFFFFFFFFFFFFF, 64'hC000000000000000}, // R8
        {8'd9, 2'd1, 64'h8000000000000000, 64'h8000000000000000}, // R9  -0 down
        {8'd9, 2'd2, 64'h8000000000000000, 64'h8000000000000000}, // R9  -0 up
        {8'd9, 2'd2, 64'h0000000000000000, 64'h0000000000000000}, // R9  +0 up
        {8'd9, 2'd3, 64'h3FF8000000000000, 64'h3FF0000000000000}, // R9  mode 11
        {8'd9, 2'd3, 64'hBFF8000000000000, 64'hBFF0000000000000}  // R9  mode 11
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst        = 1'b1;
        in_valid   = 1'b0;
        in_mode    = 2'd0;
        in_operand = '0;
        repeat (3) @(negedge clk);
        // R11: state right after reset
        check("R11 valid after reset", {63'd0, out_valid}, 64'd0);
        check("R11 result after reset", out_result, 64'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            in_valid   = 1'b1;
            in_mode    = VEC[i][129:128];
            in_operand = VEC[i][127:64];
            @(negedge clk);
            in_valid = 1'b0;
            check($sformatf("R%0d vector %0d", VEC[i][137:130], i), out_result, VEC[i][63:0]);
            check("R10 valid one cycle later", {63'd0, out_valid}, 64'd1);
        end

        // R10: idle cycles drop valid and keep the last result
        @(negedge clk);
        in_mode    = 2'd2;
        in_operand = 64'h3FF8000000000000;
        @(negedge clk);
        check("R10 valid low when idle", {63'd0, out_valid}, 64'd0);
        check("R10 result held when idle", out_result, 64'hBFF0000000000000);

        // R10: back-to-back beats, one result per cycle
        in_valid   = 1'b1;
        in_mode    = 2'd2;
        in_operand = 64'h3FF8000000000000;
        @(negedge clk);
        check("R10 stream beat 1", out_result, 64'h4000000000000000);
        in_mode    = 2'd1;
        in_operand = 64'hBFF8000000000000;
        @(negedge clk);
        check("R10 stream beat 2", out_result, 64'hC000000000000000);
        check("R10 stream valid", {63'd0, out_valid}, 64'd1);

        // R11: reset while busy clears the output stage
        rst = 1'b1;
        @(negedge clk);
        check("R11 valid cleared", {63'd0, out_valid}, 64'd0);
        check("R11 result cleared", out_result, 64'd0);
        rst      = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule